// File: doc/BRIEF.md
# Symbol-Error-Rate Lock Detector

This block judges whether a QAM receiver's loops have converged by estimating how often the slicer makes a wrong decision. For each symbol at the equalizer output it receives the magnitude of the slicer error on the in-phase and quadrature rails, along with a valid strobe. A symbol whose error on either rail exceeds a fixed fraction of the decision distance is counted as a probable symbol error. Valid symbols are grouped into fixed-length windows. The error count of each completed window is published as the SER estimate, and it is compared against a threshold that software can program.

Lock is declared only after a run of consecutive windows below the threshold. A single bad window drops it. While the receiver is locked, the detector does not wait for a window to end: as soon as the running error count reaches the threshold, lock is released. This lets the unlock indication lead the other loops. The lock flag also drives a mode output that moves the carrier detector from phase-frequency operation (unlocked) to phase-only operation (locked). A synchronous clear input restarts the measurement and forces the unlocked state.

Top module: `ser_lock_detect`

## Requirements
- R1: A valid symbol is counted as an error when `err_i_mag_i > ERR_LIMIT` or `err_q_mag_i > ERR_LIMIT`. A magnitude exactly equal to `ERR_LIMIT` on both rails is not an error.
- R2: A window consists of exactly `WIN_LEN` symbols sampled with `sym_vld_i` high. Cycles with `sym_vld_i` low are ignored, whatever the error inputs carry.
- R3: From the clock edge that samples a window's final symbol, `ser_est_o` holds that window's error count. It then keeps this value until the next window completes.
- R4: The threshold register loads `thr_wdata_i` on any edge where `thr_we_i` is high. Its reset value is `DEF_THRESH`, which defaults to 82 for a 4096-symbol window.
- R5: A window is good when its error count is strictly below the threshold. `lock_o` rises at the edge after the final symbol of the `LOCK_WINS`-th consecutive good window.
- R6: When a window completes with an error count greater than or equal to the threshold, `lock_o` is low from the following edge on, and the good-window run restarts.
- R7: While locked, once the running error count of the current window reaches the threshold, `lock_o` falls at the next edge, before the window completes.
- R8: `pd_only_o` is 1 (phase-only carrier detector) while locked and 0 (phase-frequency detector) while unlocked.
- R9: A cycle with `clr_i` high clears the symbol and error counters, the SER estimate and the good-window run, and forces `lock_o` low. Symbols from before the clear never reach an estimate.
- R10: After reset, `lock_o` and `pd_only_o` are 0, `ser_est_o` is 0, and the threshold equals `DEF_THRESH`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| clr_i | input | 1 | Synchronous clear of measurement and lock state |
| sym_vld_i | input | 1 | Symbol strobe for the error magnitudes |
| err_i_mag_i | input | ERR_W | In-phase slicer error magnitude |
| err_q_mag_i | input | ERR_W | Quadrature slicer error magnitude |
| thr_we_i | input | 1 | Threshold write enable |
| thr_wdata_i | input | CNT_W | New threshold, in errors per window |
| lock_o | output | 1 | Lock indication |
| pd_only_o | output | 1 | Carrier detector mode: 1 phase-only, 0 phase-frequency |
| ser_est_o | output | CNT_W | Error count of the last completed window |

## Verification
The bench builds the block with a 16-symbol window, an error limit of 40, a default threshold of 5 and a lock run of two windows. With these values each window takes only a few dozen cycles. That puts the full range of counts within reach: zero errors, counts just below and exactly at the threshold, and a window made entirely of errors. The small window also leaves room for mid-window events, namely the early drop and a clear arriving part-way through a window. Thresholds of 1 and 0 are then written to reach the edge where a single error, or no error at all, already spoils a window.

// File: rtl/lockdet_pkg.sv
package lockdet_pkg;

  // Carrier detector selection driven by the lock state
  typedef enum logic {
    DET_PHASE_FREQ = 1'b0,
    DET_PHASE_ONLY = 1'b1
  } det_mode_e;

  function automatic det_mode_e mode_for_lock(input logic locked);
    return locked ? DET_PHASE_ONLY : DET_PHASE_FREQ;
  endfunction

endpackage

// File: rtl/lockdet_rst_sync.sv
module lockdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shreg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg_q <= '0;
    else        shreg_q <= {shreg_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = shreg_q[STAGES-1];

endmodule

// File: rtl/ser_sym_classifier.sv
module ser_sym_classifier #(
  parameter int ERR_W     = 10,
  parameter int ERR_LIMIT = 128
) (
  input  logic             vld_i,
  input  logic [ERR_W-1:0] mag_i_i,
  input  logic [ERR_W-1:0] mag_q_i,
  output logic             sym_err_o
);

  localparam logic [ERR_W-1:0] LIMIT = ERR_W'(ERR_LIMIT);

  logic over_i, over_q;

  always_comb begin
    over_i    = mag_i_i > LIMIT;
    over_q    = mag_q_i > LIMIT;
    sym_err_o = vld_i & (over_i | over_q);
  end

endmodule

// File: rtl/ser_thresh_reg.sv
module ser_thresh_reg #(
  parameter int CNT_W      = 13,
  parameter int DEF_THRESH = 82
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] thresh_o
);

  logic [CNT_W-1:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (we_i) thr_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= CNT_W'(DEF_THRESH);
    else        thr_q <= thr_d;
  end

  assign thresh_o = thr_q;

  a_r4_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (thr_q == $past(wdata_i)));

  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(thr_q));

endmodule

// File: rtl/ser_window_counter.sv
module ser_window_counter #(
  parameter int WIN_LEN = 4096,
  parameter int CNT_W   = 13,
  localparam int IDX_W  = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             vld_i,
  input  logic             sym_err_i,
  output logic             win_done_o,
  output logic [CNT_W-1:0] win_cnt_o,
  output logic [CNT_W-1:0] run_cnt_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN_LEN - 1);

  logic [IDX_W-1:0] sym_q, sym_d;
  logic [CNT_W-1:0] err_q, err_d;
  logic [CNT_W-1:0] est_q, est_d;
  logic             done_q, done_d;
  logic             at_last;
  logic [CNT_W-1:0] err_inc;

  always_comb begin
    at_last = (sym_q == LAST_IDX);
    err_inc = err_q + {{(CNT_W-1){1'b0}}, sym_err_i};
    sym_d   = sym_q;
    err_d   = err_q;
    est_d   = est_q;
    done_d  = 1'b0;
    if (clr_i) begin
      sym_d = '0;
      err_d = '0;
      est_d = '0;
    end else if (vld_i) begin
      if (at_last) begin
        sym_d  = '0;
        err_d  = '0;
        est_d  = err_inc;
        done_d = 1'b1;
      end else begin
        sym_d = sym_q + 1'b1;
        err_d = err_inc;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q  <= '0;
      err_q  <= '0;
      est_q  <= '0;
      done_q <= 1'b0;
    end else begin
      sym_q  <= sym_d;
      err_q  <= err_d;
      est_q  <= est_d;
      done_q <= done_d;
    end
  end

  assign win_done_o = done_q;
  assign win_cnt_o  = est_q;
  assign run_cnt_o  = err_q;

  a_r2_index_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    sym_q <= LAST_IDX);

  a_r3_errors_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    err_q <= CNT_W'(sym_q));

  a_r2_idle_holds_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!vld_i && !clr_i) |=> ($stable(sym_q) && $stable(err_q) && $stable(est_q)));

  a_r9_clear_counts: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (sym_q == '0 && err_q == '0 && est_q == '0 && !done_q));

endmodule

// File: rtl/lock_hyst_fsm.sv
module lock_hyst_fsm #(
  parameter int CNT_W     = 13,
  parameter int LOCK_WINS = 2,
  localparam int RUN_W    = $clog2(LOCK_WINS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             win_done_i,
  input  logic [CNT_W-1:0] win_cnt_i,
  input  logic [CNT_W-1:0] run_cnt_i,
  input  logic [CNT_W-1:0] thresh_i,
  output logic             lock_o
);

  localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(LOCK_WINS);
  localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(LOCK_WINS - 1);

  logic             lock_q, lock_d;
  logic [RUN_W-1:0] good_q, good_d;
  logic             win_good;
  logic             run_bad;

  always_comb begin
    win_good = win_cnt_i < thresh_i;
    run_bad  = run_cnt_i >= thresh_i;
    lock_d   = lock_q;
    good_d   = good_q;
    if (clr_i) begin
      lock_d = 1'b0;
      good_d = '0;
    end else if (win_done_i) begin
      if (win_good) begin
        if (good_q != RUN_MAX) good_d = good_q + 1'b1;
        if (good_q >= RUN_LAST) lock_d = 1'b1;
      end else begin
        good_d = '0;
        lock_d = 1'b0;
      end
    end else if (lock_q && run_bad) begin
      good_d = '0;
      lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b0;
      good_q <= '0;
    end else begin
      lock_q <= lock_d;
      good_q <= good_d;
    end
  end

  assign lock_o = lock_q;

  a_r5_lock_follows_window: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_q) |-> $past(win_done_i));

  a_r6_bad_window_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    (win_done_i && (win_cnt_i >= thresh_i)) |=> (!lock_q && good_q == '0));

  a_r7_early_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !win_done_i && (run_cnt_i >= thresh_i)) |=> !lock_q);

  a_r9_clear_unlocks: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (!lock_q && good_q == '0));

  a_r5_run_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    good_q <= RUN_MAX);

endmodule

// File: rtl/ser_lock_detect.sv
module ser_lock_detect #(
  parameter int ERR_W      = 10,
  parameter int ERR_LIMIT  = 128,
  parameter int WIN_LEN    = 4096,
  parameter int DEF_THRESH = 82,
  parameter int LOCK_WINS  = 2,
  parameter int CNT_W      = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             sym_vld_i,
  input  logic [ERR_W-1:0] err_i_mag_i,
  input  logic [ERR_W-1:0] err_q_mag_i,
  input  logic             thr_we_i,
  input  logic [CNT_W-1:0] thr_wdata_i,
  output logic             lock_o,
  output logic             pd_only_o,
  output logic [CNT_W-1:0] ser_est_o
);

  import lockdet_pkg::*;

  logic             rst_n_s;
  logic             sym_err;
  logic             win_done;
  logic [CNT_W-1:0] win_cnt;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] thresh;
  logic             locked;
  det_mode_e        det_mode;

  lockdet_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ser_sym_classifier #(.ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT)) u_classify (
    .vld_i     (sym_vld_i),
    .mag_i_i   (err_i_mag_i),
    .mag_q_i   (err_q_mag_i),
    .sym_err_o (sym_err)
  );

  ser_window_counter #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_window (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (clr_i),
    .vld_i      (sym_vld_i),
    .sym_err_i  (sym_err),
    .win_done_o (win_done),
    .win_cnt_o  (win_cnt),
    .run_cnt_o  (run_cnt)
  );

  ser_thresh_reg #(.CNT_W(CNT_W), .DEF_THRESH(DEF_THRESH)) u_thresh (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .we_i     (thr_we_i),
    .wdata_i  (thr_wdata_i),
    .thresh_o (thresh)
  );

  lock_hyst_fsm #(.CNT_W(CNT_W), .LOCK_WINS(LOCK_WINS)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .clr_i      (clr_i),
    .win_done_i (win_done),
    .win_cnt_i  (win_cnt),
    .run_cnt_i  (run_cnt),
    .thresh_i   (thresh),
    .lock_o     (locked)
  );

  always_comb det_mode = mode_for_lock(locked);

  assign lock_o    = locked;
  assign pd_only_o = (det_mode == DET_PHASE_ONLY);
  assign ser_est_o = win_cnt;

  a_r8_mode_tracks_lock: assert property (@(posedge clk) disable iff (!rst_n_s)
    pd_only_o == lock_o);

endmodule

// File: tb/ser_lock_detect_tb.sv
module ser_lock_detect_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ERR_W      = 8;
  localparam int ERR_LIMIT  = 40;
  localparam int WIN_LEN    = 16;
  localparam int DEF_THRESH = 5;
  localparam int LOCK_WINS  = 2;
  localparam int CNT_W      = $clog2(WIN_LEN + 1);
  localparam int NVEC       = 7;

  // one entry per window: errors, errors on Q rail, idle gaps, expected estimate, expected lock
  localparam int V_NERR [NVEC] = '{2, 0, 4, 5, 16, 4, 1};
  localparam int V_ONQ  [NVEC] = '{0, 0, 1, 0, 1,  0, 0};
  localparam int V_GAP  [NVEC] = '{0, 0, 0, 0, 1,  1, 0};
  localparam int V_EST  [NVEC] = '{2, 0, 4, 5, 16, 4, 1};
  localparam int V_LOCK [NVEC] = '{0, 1, 1, 0, 0,  0, 1};

  logic             clk;
  logic             rst_n;
  logic             clr_i;
  logic             sym_vld_i;
  logic [ERR_W-1:0] err_i_mag_i;
  logic [ERR_W-1:0] err_q_mag_i;
  logic             thr_we_i;
  logic [CNT_W-1:0] thr_wdata_i;
  logic             lock_o;
  logic             pd_only_o;
  logic [CNT_W-1:0] ser_est_o;

  int n_chk;
  int n_bad;
  bit done;

  ser_lock_detect #(
    .ERR_W(ERR_W), .ERR_LIMIT(ERR_LIMIT), .WIN_LEN(WIN_LEN),
    .DEF_THRESH(DEF_THRESH), .LOCK_WINS(LOCK_WINS), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .sym_vld_i(sym_vld_i),
    .err_i_mag_i(err_i_mag_i), .err_q_mag_i(err_q_mag_i),
    .thr_we_i(thr_we_i), .thr_wdata_i(thr_wdata_i),
    .lock_o(lock_o), .pd_only_o(pd_only_o), .ser_est_o(ser_est_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // idle cycle with large magnitudes that must be ignored (R2)
  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      sym_vld_i   = 1'b0;
      err_i_mag_i = '1;
      err_q_mag_i = '1;
      tick();
    end
  endtask

  // clean symbols sit exactly at the limit (R1 boundary)
  task automatic send_sym(input bit is_err, input bit on_q);
    sym_vld_i   = 1'b1;
    err_i_mag_i = ERR_W'(ERR_LIMIT);
    err_q_mag_i = ERR_W'(ERR_LIMIT);
    if (is_err) begin
      if (on_q) err_q_mag_i = ERR_W'(ERR_LIMIT + 1);
      else      err_i_mag_i = ERR_W'(ERR_LIMIT + 1);
    end
    tick();
    sym_vld_i = 1'b0;
  endtask

  task automatic send_window(input int nerr, input bit on_q, input bit gaps);
    for (int s = 0; s < WIN_LEN; s++) begin
      send_sym(s < nerr, on_q);
      if (gaps) idle(1);
    end
    idle(3);
  endtask

  task automatic write_thr(input int v);
    thr_we_i    = 1'b1;
    thr_wdata_i = CNT_W'(v);
    tick();
    thr_we_i    = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; clr_i = 1'b0; sym_vld_i = 1'b0;
    err_i_mag_i = '0; err_q_mag_i = '0;
    thr_we_i = 1'b0; thr_wdata_i = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    idle(4);

    // R10 reset state
    chk("R10 lock after reset", int'(lock_o), 0);
    chk("R10 mode after reset", int'(pd_only_o), 0);
    chk("R10 estimate after reset", int'(ser_est_o), 0);

    // vector walk: R1 R2 R3 R5 R6 R8, default threshold (R10/R4)
    for (int v = 0; v < NVEC; v++) begin
      send_window(V_NERR[v], V_ONQ[v] != 0, V_GAP[v] != 0);
      chk($sformatf("R3 estimate vec %0d", v), int'(ser_est_o), V_EST[v]);
      chk($sformatf("R5/R6 lock vec %0d", v), int'(lock_o), V_LOCK[v]);
      chk($sformatf("R8 mode vec %0d", v), int'(pd_only_o), V_LOCK[v]);
    end

    // R7 early drop: locked, five errors then pause mid-window
    for (int s = 0; s < 5; s++) send_sym(1'b1, 1'b0);
    idle(2);
    chk("R7 lock drops mid-window", int'(lock_o), 0);
    chk("R8 mode follows early drop", int'(pd_only_o), 0);
    chk("R3 estimate held mid-window", int'(ser_est_o), 1);
    for (int s = 5; s < WIN_LEN; s++) send_sym(1'b0, 1'b0);
    idle(3);
    chk("R3 estimate after early drop", int'(ser_est_o), 5);
    chk("R6 still unlocked", int'(lock_o), 0);

    // R4 threshold of 1: one error is already a bad window
    write_thr(1);
    send_window(0, 1'b0, 1'b0);
    send_window(0, 1'b0, 1'b0);
    chk("R4 lock at threshold 1", int'(lock_o), 1);
    send_window(1, 1'b1, 1'b0);
    chk("R6 count equal to threshold unlocks", int'(lock_o), 0);
    chk("R3 single error estimate", int'(ser_est_o), 1);

    // R4 threshold of 0: never good
    write_thr(0);
    send_window(0, 1'b0, 1'b0);
    send_window(0, 1'b0, 1'b0);
    chk("R4 threshold 0 never locks", int'(lock_o), 0);

    // R9 synchronous clear part-way through a window
    write_thr(5);
    send_window(2, 1'b0, 1'b0);
    send_window(0, 1'b0, 1'b0);
    chk("R9 locked before clear", int'(lock_o), 1);
    for (int s = 0; s < 7; s++) send_sym(s < 3, 1'b0);
    clr_i = 1'b1;
    tick();
    clr_i = 1'b0;
    chk("R9 lock cleared", int'(lock_o), 0);
    chk("R9 estimate cleared", int'(ser_est_o), 0);
    send_window(0, 1'b0, 1'b0);
    chk("R9 old symbols discarded", int'(ser_est_o), 0);
    chk("R9 run restarted", int'(lock_o), 0);
    send_window(4, 1'b0, 1'b0);
    chk("R5 relock after clear", int'(lock_o), 1);
    chk("R3 estimate after relock", int'(ser_est_o), 4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule